// File: doc/BRIEF.md
# Banked Nibble Data Address Mapper

This block sits between the instruction decoder and the nibble-wide data RAM of a small 4-bit processor core. It converts an operand into a 12-bit physical nibble address. The operand can be a direct 8-bit field, an 8-bit indirect pointer value, or a working-register index. The conversion uses the memory-bank enable flag, the 4-bit selected memory bank, the register-bank enable flag and the 2-bit selected register bank.

The block also checks that the access width fits the target. A pair (8-bit) access must land on an even address. A pair access into the display nibbles at 1E0H–1FFH is marked as not width-legal. Accesses that cannot be resolved raise a fault, and when that happens the previously resolved address is kept.

All three outputs are registered. A request presented before a rising clock edge is visible on the outputs after that edge.

Top module: `nibble_addr_map`

## Requirements
- R1: While reset is asserted (rstN low), and immediately after it is released, physAddr is 000H and both widthOk and fault are 0.
- R2: The outputs change only at a rising clock edge. A request driven before an edge is reflected on physAddr, widthOk and fault after that edge, and the outputs keep their values between edges.
- R3: When accKind is 0 (direct) and memBankEn is 0, operands 00H–7FH map to 000H–07FH. Operands 80H–FFH map to F80H–FFFH, the I/O bank.
- R4: When accKind is 1 (indirect) and memBankEn is 0, the address is always {0H, operand}, whatever the value of memBankSel.
- R5: When memBankEn is 1, direct and indirect accesses map to {memBankSel, operand} for the existing banks 0, 1 and 15.
- R6: When memBankEn is 1 and memBankSel is not 0, 1 or 15, a direct or indirect access raises fault and physAddr holds its previous value.
- R7: When accKind is 2 (working register), the address is regBank*8 + operand[2:0]. Here regBank is regBankSel when regBankEn is 1, and 0 otherwise. memBankEn, memBankSel and operand[7:3] have no effect.
- R8: Register indices 0 to 7 name A, E, L, H, X, W, Z and Y in that order. A pair access on index 0, 2, 4 or 6 (A, L, X, Z as the low nibble) is legal and gives widthOk = 1.
- R9: When accWidth is 2 (pair) and the resolved address is odd, fault goes to 1, widthOk goes to 0 and physAddr holds its previous value.
- R10: A pair access that resolves into 1E0H–1FFH updates physAddr with widthOk = 0 and fault = 0. Bit (accWidth 0) and nibble (accWidth 1) accesses there have widthOk = 1.
- R11: An accKind of 3 or an accWidth of 3 is reserved. Either one raises fault and holds physAddr.
- R12: Every other access updates physAddr with widthOk = 1 and fault = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| accKind | input | 2 | 0 direct, 1 indirect, 2 working register, 3 reserved |
| operand | input | 8 | Direct field, pointer value, or register index in bits 2:0 |
| memBankEn | input | 1 | Memory-bank enable flag |
| memBankSel | input | 4 | Selected memory bank |
| regBankEn | input | 1 | Register-bank enable flag |
| regBankSel | input | 2 | Selected register bank |
| accWidth | input | 2 | 0 bit, 1 nibble, 2 pair, 3 reserved |
| physAddr | output | 12 | Resolved physical nibble address |
| widthOk | output | 1 | Access width is legal at this address |
| fault | output | 1 | Access could not be resolved; address held |

## Verification
The bench drives direct operands at 7FH and 80H, on either side of the split. A mapper that tests the wrong operand bit sends one of them to the wrong bank. It then sets the bank-enable flags to values that must be ignored, which catches a mapper that lets memBankSel leak into indirect or working-register accesses, or that honours regBankSel while regBankEn is clear. After each faulting request (bank 5, odd pair, reserved codes) it reads physAddr back and compares it with the address from the request before. A design that loads on fault would show the rejected address. Pair accesses at 1DEH and 1E4H probe the edge of the display window. A wrong comparison either refuses a legal pair or accepts an illegal one.

// File: rtl/nibmap_pkg.sv
package nibmap_pkg;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 8;
  localparam int BANK_W = ADDR_W - OFF_W;
  localparam int RB_W   = 2;
  localparam int RIDX_W = 3;

  typedef enum logic [1:0] {
    KIND_DIRECT   = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_WREG     = 2'd2,
    KIND_RSVD     = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    WID_BIT  = 2'd0,
    WID_NIB  = 2'd1,
    WID_PAIR = 2'd2,
    WID_RSVD = 2'd3
  } width_e;

  // address source chosen by control
  typedef enum logic [1:0] {
    SRC_SPLIT = 2'd0,  // direct, bank enable clear: bank 0 or I/O bank
    SRC_LOW   = 2'd1,  // indirect, bank enable clear: bank 0
    SRC_SEL   = 2'd2,  // selected memory bank
    SRC_WREG  = 2'd3   // working register area
  } src_e;

  typedef struct packed {
    logic loadAddr;
    logic faultNext;
    logic okNext;
  } strobe_t;
endpackage

// File: rtl/nibmap_ctrl.sv
module nibmap_ctrl
  import nibmap_pkg::*;
#(
  parameter int unsigned NUM_DATA_BANKS = 2,
  parameter int unsigned IO_BANK        = 15,
  parameter int unsigned DISP_BASE      = 'h1E0,
  parameter int unsigned DISP_SIZE      = 32
) (
  input  kind_e                    kind,
  input  width_e                   width,
  input  logic                     memBankEn,
  input  logic [BANK_W-1:0]        memBankSel,
  input  logic [ADDR_W-1:0]        candAddr,
  output src_e                     srcSel,
  output strobe_t                  strobes
);
  localparam logic [ADDR_W-1:0] DISP_LO = ADDR_W'(DISP_BASE);
  localparam logic [ADDR_W-1:0] DISP_HI = ADDR_W'(DISP_BASE + DISP_SIZE - 1);
  localparam logic [BANK_W-1:0] IO_ID   = BANK_W'(IO_BANK);

  // one match bit per ordinary data bank
  logic [NUM_DATA_BANKS-1:0] bankHit;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_DATA_BANKS; gi++) begin : g_bank
      assign bankHit[gi] = (memBankSel == BANK_W'(gi));
    end
  endgenerate

  logic bankValid;
  assign bankValid = (|bankHit) || (memBankSel == IO_ID);

  always_comb begin
    unique case (kind)
      KIND_WREG:     srcSel = SRC_WREG;
      KIND_INDIRECT: srcSel = memBankEn ? SRC_SEL : SRC_LOW;
      default:       srcSel = memBankEn ? SRC_SEL : SRC_SPLIT;
    endcase
  end

  logic kindBad, widthBad, bankBad, oddPair, dispHit;
  assign kindBad  = (kind == KIND_RSVD);
  assign widthBad = (width == WID_RSVD);
  assign bankBad  = (srcSel == SRC_SEL) && !bankValid;
  assign oddPair  = (width == WID_PAIR) && candAddr[0];
  assign dispHit  = (candAddr >= DISP_LO) && (candAddr <= DISP_HI);

  always_comb begin
    strobes.faultNext = kindBad || widthBad || bankBad || oddPair;
    strobes.loadAddr  = !strobes.faultNext;
    strobes.okNext    = !strobes.faultNext && !((width == WID_PAIR) && dispHit);
  end

  // R6: a bank outside the set never passes as valid
  always_comb begin
    a_r6_bank_set : assert (!(bankValid && !(memBankSel == '0 || memBankSel == BANK_W'(1)
                              || memBankSel == IO_ID)) || NUM_DATA_BANKS != 2)
      else $error("bank validity disagrees with bank set");
  end
endmodule

// File: rtl/nibmap_dpath.sv
module nibmap_dpath
  import nibmap_pkg::*;
#(
  parameter int unsigned IO_BANK = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  src_e                srcSel,
  input  logic [OFF_W-1:0]    operand,
  input  logic [BANK_W-1:0]   memBankSel,
  input  logic                regBankEn,
  input  logic [RB_W-1:0]     regBankSel,
  input  strobe_t             strobes,
  output logic [ADDR_W-1:0]   candAddr,
  output logic [ADDR_W-1:0]   physAddr,
  output logic                widthOk,
  output logic                fault
);
  localparam int            WREG_PAD = ADDR_W - RB_W - RIDX_W;
  localparam logic [BANK_W-1:0] IO_ID = BANK_W'(IO_BANK);

  logic [RB_W-1:0] regBank;
  assign regBank = regBankEn ? regBankSel : '0;

  always_comb begin
    unique case (srcSel)
      SRC_SPLIT: candAddr = {(operand[OFF_W-1] ? IO_ID : {BANK_W{1'b0}}), operand};
      SRC_LOW:   candAddr = {{BANK_W{1'b0}}, operand};
      SRC_SEL:   candAddr = {memBankSel, operand};
      default:   candAddr = {{WREG_PAD{1'b0}}, regBank, operand[RIDX_W-1:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      widthOk  <= 1'b0;
      fault    <= 1'b0;
    end else begin
      if (strobes.loadAddr) physAddr <= candAddr;
      widthOk <= strobes.okNext;
      fault   <= strobes.faultNext;
    end
  end

  a_r9_hold_on_fault : assert property (@(posedge clk) disable iff (!rstN)
    fault |-> physAddr == $past(physAddr))
    else $error("address moved on a faulting access");

  a_r12_ok_excludes_fault : assert property (@(posedge clk) disable iff (!rstN)
    !(widthOk && fault))
    else $error("widthOk and fault both high");
endmodule

// File: rtl/nibble_addr_map.sv
module nibble_addr_map
  import nibmap_pkg::*;
#(
  parameter int unsigned NUM_DATA_BANKS = 2,
  parameter int unsigned IO_BANK        = 15,
  parameter int unsigned DISP_BASE      = 'h1E0,
  parameter int unsigned DISP_SIZE      = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  accKind,
  input  logic [7:0]  operand,
  input  logic        memBankEn,
  input  logic [3:0]  memBankSel,
  input  logic        regBankEn,
  input  logic [1:0]  regBankSel,
  input  logic [1:0]  accWidth,
  output logic [11:0] physAddr,
  output logic        widthOk,
  output logic        fault
);
  src_e              srcSel;
  strobe_t           strobes;
  logic [ADDR_W-1:0] candAddr;

  nibmap_ctrl #(
    .NUM_DATA_BANKS(NUM_DATA_BANKS),
    .IO_BANK(IO_BANK),
    .DISP_BASE(DISP_BASE),
    .DISP_SIZE(DISP_SIZE)
  ) uCtrl (
    .kind(kind_e'(accKind)),
    .width(width_e'(accWidth)),
    .memBankEn(memBankEn),
    .memBankSel(memBankSel),
    .candAddr(candAddr),
    .srcSel(srcSel),
    .strobes(strobes)
  );

  nibmap_dpath #(.IO_BANK(IO_BANK)) uDpath (
    .clk(clk),
    .rstN(rstN),
    .srcSel(srcSel),
    .operand(operand),
    .memBankSel(memBankSel),
    .regBankEn(regBankEn),
    .regBankSel(regBankSel),
    .strobes(strobes),
    .candAddr(candAddr),
    .physAddr(physAddr),
    .widthOk(widthOk),
    .fault(fault)
  );

  a_r3_io_split : assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd0 && !memBankEn && operand[7] && accWidth == 2'd1)
      |=> (physAddr[11:8] == 4'(IO_BANK) && !fault))
    else $error("direct upper operand missed the I/O bank");

  a_r4_low_bank : assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd1 && !memBankEn && accWidth == 2'd1)
      |=> (physAddr[11:8] == 4'h0 && widthOk))
    else $error("indirect access left bank 0");

  a_r7_wreg_area : assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd2 && accWidth == 2'd1) |=> (physAddr[11:5] == 7'd0 && !fault))
    else $error("working register outside its area");

  a_r6_bad_bank : assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd0 && memBankEn && memBankSel == 4'd5) |=> fault)
    else $error("missing bank not faulted");

  a_r11_reserved : assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd3 || accWidth == 2'd3) |=> (fault && $stable(physAddr)))
    else $error("reserved code not faulted");
endmodule

// File: tb/nibble_addr_map_test.sv
module nibble_addr_map_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accKind = '0;
  logic [7:0]  operand = '0;
  logic        memBankEn = 1'b0;
  logic [3:0]  memBankSel = '0;
  logic        regBankEn = 1'b0;
  logic [1:0]  regBankSel = '0;
  logic [1:0]  accWidth = 2'd1;
  logic [11:0] physAddr;
  logic        widthOk, fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nibble_addr_map uut (
    .clk(clk), .rstN(rstN), .accKind(accKind), .operand(operand),
    .memBankEn(memBankEn), .memBankSel(memBankSel), .regBankEn(regBankEn),
    .regBankSel(regBankSel), .accWidth(accWidth),
    .physAddr(physAddr), .widthOk(widthOk), .fault(fault)
  );

  task automatic chk(input string tag, input logic [11:0] expA,
                     input logic expOk, input logic expF);
    checks++;
    if (physAddr !== expA || widthOk !== expOk || fault !== expF) begin
      errors++;
      $display("FAIL %s: got addr=%03h ok=%0b fault=%0b, expected addr=%03h ok=%0b fault=%0b",
               tag, physAddr, widthOk, fault, expA, expOk, expF);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic req(input logic [1:0] k, input logic [7:0] op, input logic me,
                     input logic [3:0] ms, input logic re, input logic [1:0] rs,
                     input logic [1:0] w);
    @(negedge clk);
    accKind = k; operand = op; memBankEn = me; memBankSel = ms;
    regBankEn = re; regBankSel = rs; accWidth = w;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 during reset", 12'h000, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    #1 chk("R1 after release", 12'h000, 1'b0, 1'b0);
  endtask

  task automatic t_direct_split;
    req(2'd0, 8'h35, 0, 4'h1, 0, 0, 2'd1); chk("R3 low 35", 12'h035, 1, 0);
    req(2'd0, 8'h7F, 0, 4'h0, 0, 0, 2'd1); chk("R3 edge 7F", 12'h07F, 1, 0);
    req(2'd0, 8'h80, 0, 4'h0, 0, 0, 2'd1); chk("R3 edge 80", 12'hF80, 1, 0);
    req(2'd0, 8'hA2, 0, 4'h1, 0, 0, 2'd0); chk("R3 io A2", 12'hFA2, 1, 0);
  endtask

  task automatic t_indirect_low;
    req(2'd1, 8'hC4, 0, 4'h1, 0, 0, 2'd1); chk("R4 indirect C4", 12'h0C4, 1, 0);
  endtask

  task automatic t_selected_bank;
    req(2'd0, 8'h3C, 1, 4'h1, 0, 0, 2'd1); chk("R5 bank1 direct", 12'h13C, 1, 0);
    req(2'd1, 8'h05, 1, 4'hF, 0, 0, 2'd1); chk("R5 bank15 indirect", 12'hF05, 1, 0);
    req(2'd0, 8'h99, 1, 4'h0, 0, 0, 2'd1); chk("R5 bank0 direct", 12'h099, 1, 0);
    req(2'd0, 8'h10, 1, 4'h5, 0, 0, 2'd1); chk("R6 bank5", 12'h099, 0, 1);
    req(2'd1, 8'h10, 1, 4'hE, 0, 0, 2'd1); chk("R6 bank14", 12'h099, 0, 1);
  endtask

  task automatic t_working_regs;
    req(2'd2, 8'h02, 1, 4'h5, 0, 2'd3, 2'd1); chk("R7 forced bank0", 12'h002, 1, 0);
    req(2'd2, 8'h07, 0, 4'h0, 1, 2'd2, 2'd1); chk("R7 bank2 Y", 12'h017, 1, 0);
    req(2'd2, 8'hFD, 1, 4'h1, 1, 2'd3, 2'd0); chk("R7 bank3 W", 12'h01D, 1, 0);
    req(2'd2, 8'h04, 0, 4'h0, 1, 2'd1, 2'd2); chk("R8 pair WX", 12'h00C, 1, 0);
    req(2'd2, 8'h06, 0, 4'h0, 1, 2'd0, 2'd2); chk("R8 pair YZ", 12'h006, 1, 0);
  endtask

  task automatic t_odd_pair;
    req(2'd0, 8'h21, 0, 4'h0, 0, 0, 2'd2); chk("R9 odd direct", 12'h006, 0, 1);
    req(2'd2, 8'h03, 0, 4'h0, 1, 2'd1, 2'd2); chk("R9 odd reg H", 12'h006, 0, 1);
  endtask

  task automatic t_display;
    req(2'd0, 8'hDE, 1, 4'h1, 0, 0, 2'd2); chk("R10 pair below window", 12'h1DE, 1, 0);
    req(2'd0, 8'hE4, 1, 4'h1, 0, 0, 2'd2); chk("R10 pair in window", 12'h1E4, 0, 0);
    req(2'd1, 8'hFF, 1, 4'h1, 0, 0, 2'd1); chk("R10 nibble in window", 12'h1FF, 1, 0);
  endtask

  task automatic t_reserved;
    req(2'd3, 8'h12, 0, 4'h0, 0, 0, 2'd1); chk("R11 kind 3", 12'h1FF, 0, 1);
    req(2'd0, 8'h12, 0, 4'h0, 0, 0, 2'd3); chk("R11 width 3", 12'h1FF, 0, 1);
    req(2'd0, 8'h12, 0, 4'h0, 0, 0, 2'd1); chk("R12 recovers", 12'h012, 1, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    accKind = 2'd0; operand = 8'h55; memBankEn = 0; accWidth = 2'd1;
    #2 chk("R2 before edge", 12'h012, 1, 0);
    @(negedge clk);
    chk("R2 after edge", 12'h055, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_direct_split();
    t_indirect_low();
    t_selected_bank();
    t_working_regs();
    t_odd_pair();
    t_display();
    t_reserved();
    t_timing();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule